// File: doc/BRIEF.md
# Delayed-Parity Error Checker

This block watches a registered data word whose parity bit arrives one clock after the word itself. Each cycle it may capture a new word; on the following clock it combines that stored word with the late parity bit. If the combined parity is odd, it drives an active-low error flag. The flag stays low for a fixed number of cycles (two by default). The same combined parity bit also leaves the block as a registered output, so one checker can feed the parity input of a second checker in a cascade. In a cascade, only the last stage's error flag is used.

Capturing is gated by two active-high hold inputs, select and qualifier. When both are high the word register is frozen, and the cycle that follows performs no check. A static width input chooses between the full word and a narrow low-order slice as the set of checked bits. Reset is asynchronous and active low. It releases the error flag at once and empties the parity pipeline.

Top module: `dpar_checker`

## Requirements
- R1: While `rst_n` is low, `qerr_n_o` is 1 and `ppo_o` is 0 without waiting for a clock edge, and no word is pending a check.
- R2: A word captured at clock edge n is checked at edge n+1 against `par_i` sampled at that edge. The rule is even parity: the XOR of the checked bits and `par_i` must be 0.
- R3: `ppo_o` is registered. After a checking edge it equals the XOR of the checked bits of the stored word and `par_i`. On edges that do not check, it keeps its value.
- R4: When a checking edge finds odd parity, `qerr_n_o` goes low directly after that edge and stays low for exactly HOLD_CYC (2) cycles.
- R5: An error found while `qerr_n_o` is already low restarts the hold, so the flag stays low for HOLD_CYC cycles after the most recent error.
- R6: At an edge where `dcs_n_i` and `csr_n_i` are both 1, the word register keeps its contents. The next edge then performs no check: `ppo_o` holds and no new error is raised.
- R7: With `narrow_i` = 1, only bits [NARROW_W-1:0] (bits 13..0) take part in the check, and the upper bits have no effect. With `narrow_i` = 0, all DATA_W (25) bits are checked.
- R8: The first edge after reset is released performs no check, whatever `par_i` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is registered on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_i | input | DATA_W | Data word presented for capture |
| par_i | input | 1 | Parity bit for the word presented one cycle earlier |
| dcs_n_i | input | 1 | Select hold input; freezes capture together with `csr_n_i` |
| csr_n_i | input | 1 | Qualifier hold input; freezes capture together with `dcs_n_i` |
| narrow_i | input | 1 | 1 selects the narrow checked slice, 0 selects the full word |
| ppo_o | output | 1 | Registered parity result, usable as the parity input of a following stage |
| qerr_n_o | output | 1 | Active-low error flag, stretched to HOLD_CYC cycles |

## Verification
The bound checker evaluates several properties on every clock. It confirms that each error event pulls the flag low on the next cycle, and that the flag only falls after such an event. It confirms that a low period never lasts less than the hold length, that an error can only arise while a word is pending, and that `ppo_o` stays steady on edges that do not check. Some behaviours are visible only through the bench's scenarios. These are the arithmetic correctness of the parity in both width modes, the pairing of each parity bit with the word from the cycle before, the exact two-cycle length, the restart on back-to-back errors, the freeze gating, and the immediate release under asynchronous reset.

// File: rtl/dpar_pkg.sv
package dpar_pkg;
  localparam int MAX_W = 64;

  typedef enum logic {WIDTH_FULL = 1'b0, WIDTH_NARROW = 1'b1} width_sel_e;

  // Combined parity of the selected bits and the late parity bit; 1 means odd (error).
  function automatic logic combined_parity(input logic [MAX_W-1:0] word,
                                           input logic [MAX_W-1:0] mask,
                                           input logic par);
    return (^(word & mask)) ^ par;
  endfunction
endpackage

// File: rtl/dp_capture.sv
module dp_capture #(
  parameter int DATA_W = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] d_i,
  input  logic              dcs_n_i,
  input  logic              csr_n_i,
  output logic [DATA_W-1:0] word_o,
  output logic              pend_o
);
  logic load;
  assign load = ~(dcs_n_i & csr_n_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o <= '0;
      pend_o <= 1'b0;
    end else begin
      pend_o <= load;
      if (load) word_o <= d_i;
    end
  end
endmodule

// File: rtl/dp_compare.sv
module dp_compare
  import dpar_pkg::*;
#(
  parameter int DATA_W   = 25,
  parameter int NARROW_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] word_i,
  input  logic              pend_i,
  input  logic              par_i,
  input  width_sel_e        wsel_i,
  output logic              ppo_o,
  output logic              err_o
);
  localparam int PAD_W = MAX_W - DATA_W;
  localparam logic [DATA_W-1:0] NARROW_MASK = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  localparam logic [DATA_W-1:0] FULL_MASK   = {DATA_W{1'b1}};

  logic [DATA_W-1:0] mask;
  logic              odd;

  assign mask  = (wsel_i == WIDTH_NARROW) ? NARROW_MASK : FULL_MASK;
  assign odd   = combined_parity({{PAD_W{1'b0}}, word_i}, {{PAD_W{1'b0}}, mask}, par_i);
  assign err_o = pend_i & odd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ppo_o <= 1'b0;
    else if (pend_i) ppo_o <= odd;
  end
endmodule

// File: rtl/dp_hold.sv
module dp_hold #(
  parameter int HOLD_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic err_i,
  output logic qerr_n_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(HOLD_CYC);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            remain <= '0;
    else if (err_i)        remain <= LOAD_VAL;
    else if (remain != '0) remain <= remain - 1'b1;
  end

  assign qerr_n_o = (remain == '0);
endmodule

// File: rtl/dpar_checker.sv
module dpar_checker
  import dpar_pkg::*;
#(
  parameter int DATA_W   = 25,
  parameter int NARROW_W = 14,
  parameter int HOLD_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_i,
  input  logic              dcs_n_i,
  input  logic              csr_n_i,
  input  logic              narrow_i,
  output logic              ppo_o,
  output logic              qerr_n_o
);
  // Named internal events, visible to the bound checker
  logic [DATA_W-1:0] held_word;
  logic              chk_en;
  logic              err_evt;
  width_sel_e        wsel;

  assign wsel = width_sel_e'(narrow_i);

  dp_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .d_i(data_i),
    .dcs_n_i(dcs_n_i), .csr_n_i(csr_n_i),
    .word_o(held_word), .pend_o(chk_en)
  );

  dp_compare #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .word_i(held_word), .pend_i(chk_en),
    .par_i(par_i), .wsel_i(wsel), .ppo_o(ppo_o), .err_o(err_evt)
  );

  dp_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .err_i(err_evt), .qerr_n_o(qerr_n_o)
  );
endmodule

// File: rtl/dpar_checker_sva.sv
module dpar_checker_sva #(
  parameter int HOLD_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic qerr_n,
  input logic ppo,
  input logic chk_en,
  input logic err_evt
);
  logic [7:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              low_run <= '0;
    else if (qerr_n)         low_run <= '0;
    else if (low_run != '1)  low_run <= low_run + 1'b1;
  end

  assert_err_drops_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> !qerr_n);

  assert_fall_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(qerr_n) |-> $past(err_evt));

  assert_min_low_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qerr_n) |-> (low_run >= 8'(HOLD_CYC)));

  assert_err_needs_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |-> chk_en);

  assert_ppo_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en |=> $stable(ppo));
endmodule

bind dpar_checker dpar_checker_sva #(.HOLD_CYC(HOLD_CYC)) u_sva (
  .clk(clk), .rst_n(rst_n), .qerr_n(qerr_n_o), .ppo(ppo_o),
  .chk_en(chk_en), .err_evt(err_evt)
);

// File: tb/sim_dpar_checker.sv
`timescale 1ns/1ps
module sim_dpar_checker;
  localparam int DW = 25;
  localparam int NW = 14;
  localparam int HOLD = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] data = '0;
  logic          par = 1'b0, dcs_n = 1'b0, csr_n = 1'b0, narrow = 1'b0;
  logic          ppo, qerr_n;

  int checks = 0, failures = 0;
  bit done = 0;

  // bench reference state
  logic [DW-1:0] m_word;
  logic          m_pend, m_ppo;
  int            m_cnt;

  always #5 clk = ~clk;

  dpar_checker #(.DATA_W(DW), .NARROW_W(NW), .HOLD_CYC(HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .data_i(data), .par_i(par),
    .dcs_n_i(dcs_n), .csr_n_i(csr_n), .narrow_i(narrow),
    .ppo_o(ppo), .qerr_n_o(qerr_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // parity by counting ones over the selected width
  function automatic logic odd_count(input logic [DW-1:0] w, input logic p, input logic nar);
    int n = 0;
    int lim = nar ? NW : DW;
    for (int i = 0; i < lim; i++) if (w[i]) n++;
    return logic'((n + int'(p)) % 2);
  endfunction

  task automatic model_reset();
    m_word = '0; m_pend = 0; m_ppo = 0; m_cnt = 0;
  endtask

  // one cycle: drive, clock, update the reference, compare at the falling edge
  task automatic step(input logic [DW-1:0] d, input logic p, input logic cs, input logic cr,
                      input string req);
    logic o;
    data = d; par = p; dcs_n = cs; csr_n = cr;
    @(posedge clk);
    if (m_pend) begin
      o = odd_count(m_word, p, narrow);
      m_ppo = o;
      if (o) m_cnt = HOLD;
      else if (m_cnt > 0) m_cnt--;
    end else if (m_cnt > 0) m_cnt--;
    m_pend = !(cs && cr);
    if (m_pend) m_word = d;
    @(negedge clk);
    check(ppo === m_ppo, req, int'(ppo), int'(m_ppo));
    check(qerr_n === (m_cnt == 0), req, int'(qerr_n), int'(m_cnt == 0));
  endtask

  task automatic apply_reset();
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    check(qerr_n === 1'b1, "R1", int'(qerr_n), 1);
    check(ppo === 1'b0, "R1", int'(ppo), 0);
    model_reset();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    #2000000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [DW-1:0] lfsr = 25'h1ACE5;
    logic [DW-1:0] prev;
    logic          pp;
    model_reset();
    #1;
    check(qerr_n === 1'b1, "R1", int'(qerr_n), 1);
    check(ppo === 1'b0, "R1", int'(ppo), 0);
    @(negedge clk); rst_n = 1'b1;

    // R8: first edge after release carries an odd parity bit but no pending word
    step(25'h0000001, 1'b1, 1'b0, 1'b0, "R8");
    // word 0x1 loaded; correct parity next cycle is 1
    step(25'h0000003, 1'b1, 1'b0, 1'b0, "R2");
    // word 0x3 wants parity 0: give 1 to raise an error
    step(25'h0000000, 1'b1, 1'b0, 1'b0, "R4");
    step(25'h0000000, 1'b0, 1'b0, 1'b0, "R4");
    step(25'h0000000, 1'b0, 1'b0, 1'b0, "R4");
    step(25'h0000000, 1'b0, 1'b0, 1'b0, "R4");

    // R5: errors on consecutive checks restart the hold
    step(25'h0000001, 1'b0, 1'b0, 1'b0, "R5");
    step(25'h0000001, 1'b0, 1'b0, 1'b0, "R5");
    step(25'h0000000, 1'b0, 1'b0, 1'b0, "R5");
    for (int k = 0; k < 3; k++) step('0, 1'b0, 1'b0, 1'b0, "R5");

    // R6: frozen capture, the next edge must not check even with a bad bit
    step(25'h0000007, 1'b1, 1'b0, 1'b0, "R6");
    step(25'h0000001, 1'b0, 1'b1, 1'b1, "R6");
    step(25'h0000000, 1'b1, 1'b0, 1'b1, "R6");
    step(25'h0000000, 1'b0, 1'b1, 1'b0, "R6");
    for (int k = 0; k < 3; k++) step('0, 1'b0, 1'b0, 1'b0, "R6");

    // full-width sweep with mixed errors and freezes
    prev = '0;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[DW-2:0], lfsr[24] ^ lfsr[21]};
      pp = odd_count(prev, 1'b0, 1'b0) ^ ((i % 5) == 0);
      step(lfsr, pp, (i % 7) == 3, (i % 7) == 3 || (i % 3) == 0, "R3");
      prev = lfsr;
    end

    // R7: narrow width, upper bits scrambled and must not matter
    narrow = 1'b1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[DW-2:0], lfsr[24] ^ lfsr[21]};
      pp = odd_count(prev, 1'b0, 1'b1) ^ ((i % 9) == 4);
      step(lfsr, pp, 1'b0, (i % 4) == 1, "R7");
      prev = lfsr;
    end
    // explicit: word with only upper bits set checks clean with parity 0
    step(25'h1FFC000, 1'b0, 1'b0, 1'b0, "R7");
    step(25'h0000000, 1'b0, 1'b0, 1'b0, "R7");
    narrow = 1'b0;
    step(25'h0000000, 1'b0, 1'b0, 1'b0, "R7");

    // R1: reset asserted in the middle of a hold
    step(25'h0000001, 1'b0, 1'b0, 1'b0, "R1");
    step(25'h0000000, 1'b0, 1'b0, 1'b0, "R1");
    apply_reset();
    step(25'h0000000, 1'b1, 1'b0, 1'b0, "R1");
    step(25'h0000000, 1'b0, 1'b0, 1'b0, "R1");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule